// File: doc/BRIEF.md
# Key-Aware Cipher Job Dispatcher

This block sits between a job source and a row of twelve block-cipher engines. Each job names a flow, a key address and a count of 128-bit blocks. The dispatcher picks an idle engine and places the job there. Each engine owns a small local store with eight slots for expanded key schedules. The dispatcher keeps a tag table that records which key address sits in each slot of each engine. An engine that already holds the key costs no reload, so the dispatcher prefers it.

When no idle engine holds the key, the dispatcher picks an idle engine in round-robin order and chooses a victim slot in that engine, also round-robin. It asks the key-expansion unit for the schedule and forwards each round-key beat to the engine's schedule write port with a word index. Only after the last beat has been written does it issue the job. An issued engine counts as busy until its done pulse. A job whose flow is still running on some engine is held back, so that chained blocks of one flow never run in parallel.

Top module: `job_row_sched`

## Requirements
- R1: After reset no engine is busy, no slot holds a valid key, the round-robin engine pointer and every engine's victim pointer are 0, `job_ready` is 1, and `iss_valid` and `ks_req` are 0.
- R2: When an idle engine holds the job's key address in a valid slot, the job goes to such an engine without a schedule request. `iss_valid` is high in the cycle after acceptance, with that slot in `iss_slot`. If several idle engines hold the key, the first one in round-robin order is taken.
- R3: When no idle engine holds the key, the job goes to the first idle engine in round-robin order. From the cycle after acceptance, `ks_req` stays high with `ks_req_key` equal to the job's key address until the beat flagged `ks_last` arrives.
- R4: While `ks_req` is high, each `ks_valid` beat appears in the same cycle on `ksw_en` and `ksw_data`, with the chosen engine in `ksw_eng`, the chosen slot in `ksw_slot`, and `ksw_word` counting 0, 1, 2 and so on per beat.
- R5: `iss_valid` rises in the cycle after the last schedule beat. From then on the slot holds the new key, so a later job with that key hits.
- R6: Within one engine, the victim slots for misses follow the order 0, 1, 2 and so on, wrapping after slot 7. Slots are replaced whether or not they are valid.
- R7: After a job is placed on engine e, the next round-robin search starts at engine e+1, wrapping from engine 11 to 0.
- R8: Issuing sets `eng_busy` for the chosen engine. A busy engine is never chosen, even when it holds the key.
- R9: A one-cycle pulse on `eng_done[e]` clears `eng_busy[e]` at the next clock edge. A job may be accepted in that same cycle, but it cannot be placed on engine e.
- R10: `job_ready` is 0 while a busy engine runs a job with the same flow ID as the offered job.
- R11: `job_ready` is 0 while all engines are busy or a schedule load is in progress.
- R12: `iss_flow` and `iss_nblk` carry the accepted job's flow ID and block count (1 to 16, binary) along with `iss_eng` and `iss_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Job accepted when high with job_valid |
| job_flow | input | 4 | Flow ID of the job |
| job_key | input | 8 | Key store address |
| job_nblk | input | 5 | Number of 128-bit blocks, 1 to 16 |
| ks_req | output | 1 | Schedule requested from the key expander |
| ks_req_key | output | 8 | Key address of the requested schedule |
| ks_valid | input | 1 | Schedule beat present |
| ks_last | input | 1 | Final beat of the schedule |
| ks_data | input | 128 | Round-key beat |
| ksw_en | output | 1 | Engine schedule memory write enable |
| ksw_eng | output | 4 | Target engine |
| ksw_slot | output | 3 | Target slot |
| ksw_word | output | 4 | Round-key index within the slot |
| ksw_data | output | 128 | Round-key data |
| iss_valid | output | 1 | Job issue pulse |
| iss_eng | output | 4 | Engine receiving the job |
| iss_slot | output | 3 | Slot holding the job's schedule |
| iss_flow | output | 4 | Flow ID of the issued job |
| iss_nblk | output | 5 | Block count of the issued job |
| eng_done | input | 12 | Completion pulse per engine |
| eng_busy | output | 12 | Busy flag per engine |

## Verification
The case that needs care is a completion and an acceptance in the same clock: an engine's done pulse clears its busy flag while the dispatcher is choosing an engine for a new job. The bench offers a job whose key is held only by an engine that is busy, and raises that engine's done pulse in the very cycle the job is accepted. The check passes if the job goes to another idle engine as a miss, with the round-robin pointer advanced, and if the freed engine shows as idle one cycle later. A following job with the same key then has to hit on the freed engine.

// File: rtl/job_sched_pkg.sv
package job_sched_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_LOAD = 1'b1
   } sched_state_e;

   function automatic int unsigned wrap_inc(input int unsigned val, input int unsigned limit);
      return (val + 1 >= limit) ? 0 : val + 1;
   endfunction

endpackage

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
   parameter int N = 12,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] req,
   input  logic [W-1:0] ptr,
   output logic         gnt_v,
   output logic [W-1:0] gnt_idx
);

   always_comb begin
      gnt_v   = 1'b0;
      gnt_idx = '0;
      for (int k = 0; k < N; k++) begin
         logic [W:0] cand;
         cand = {1'b0, ptr} + (W+1)'(k);
         if (cand >= (W+1)'(N)) cand = cand - (W+1)'(N);
         if (!gnt_v && req[cand]) begin
            gnt_v   = 1'b1;
            gnt_idx = cand[W-1:0];
         end
      end
   end

endmodule

// File: rtl/sched_key_tags.sv
module sched_key_tags #(
   parameter int NUM_ENG  = 12,
   parameter int NUM_SLOT = 8,
   parameter int KEY_W    = 8,
   localparam int ENG_W  = $clog2(NUM_ENG),
   localparam int SLOT_W = $clog2(NUM_SLOT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [KEY_W-1:0]   lookup_key,
   input  logic [ENG_W-1:0]   sel_eng,
   output logic [NUM_ENG-1:0] hit_vec,
   output logic [SLOT_W-1:0]  sel_hit_slot,
   output logic [SLOT_W-1:0]  sel_victim,
   input  logic               wr_en,
   input  logic [ENG_W-1:0]   wr_eng,
   input  logic [KEY_W-1:0]   wr_key
);

   logic [NUM_SLOT-1:0] vld_q  [NUM_ENG];
   logic [KEY_W-1:0]    tag_q  [NUM_ENG][NUM_SLOT];
   logic [SLOT_W-1:0]   repl_q [NUM_ENG];
   logic [NUM_SLOT-1:0] match  [NUM_ENG];
   logic [SLOT_W-1:0]   first_hit [NUM_ENG];

   for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[e]  <= '0;
            repl_q[e] <= '0;
            for (int s = 0; s < NUM_SLOT; s++) tag_q[e][s] <= '0;
         end else if (wr_en && wr_eng == ENG_W'(e)) begin
            vld_q[e][repl_q[e]] <= 1'b1;
            tag_q[e][repl_q[e]] <= wr_key;
            repl_q[e] <= SLOT_W'(job_sched_pkg::wrap_inc(int'(repl_q[e]), NUM_SLOT));
         end
      end

      for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
         assign match[e][s] = vld_q[e][s] && (tag_q[e][s] == lookup_key);
      end

      assign hit_vec[e] = |match[e];

      always_comb begin
         first_hit[e] = '0;
         for (int s = NUM_SLOT - 1; s >= 0; s--) begin
            if (match[e][s]) first_hit[e] = SLOT_W'(s);
         end
      end
   end

   assign sel_hit_slot = first_hit[sel_eng];
   assign sel_victim   = repl_q[sel_eng];

endmodule

// File: rtl/sched_eng_state.sv
module sched_eng_state #(
   parameter int NUM_ENG = 12,
   parameter int FLOW_W  = 4,
   localparam int ENG_W = $clog2(NUM_ENG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [ENG_W-1:0]   set_eng,
   input  logic [FLOW_W-1:0]  set_flow,
   input  logic [NUM_ENG-1:0] done,
   output logic [NUM_ENG-1:0] busy,
   output logic [FLOW_W-1:0]  flow [NUM_ENG]
);

   for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
      logic hit_set;
      assign hit_set = set_en && (set_eng == ENG_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy[e] <= 1'b0;
            flow[e] <= '0;
         end else begin
            busy[e] <= (busy[e] && !done[e]) || hit_set;
            if (hit_set) flow[e] <= set_flow;
         end
      end
   end

endmodule

// File: rtl/job_row_sched.sv
module job_row_sched
   import job_sched_pkg::*;
#(
   parameter int NUM_ENG    = 12,
   parameter int NUM_SLOT   = 8,
   parameter int KEY_W      = 8,
   parameter int FLOW_W     = 4,
   parameter int NBLK_W     = 5,
   parameter int KS_WORDS   = 11,
   parameter int DATA_W     = 128,
   parameter bit PREFER_HIT = 1'b1,
   localparam int ENG_W  = $clog2(NUM_ENG),
   localparam int SLOT_W = $clog2(NUM_SLOT),
   localparam int WORD_W = $clog2(KS_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               job_valid,
   output logic               job_ready,
   input  logic [FLOW_W-1:0]  job_flow,
   input  logic [KEY_W-1:0]   job_key,
   input  logic [NBLK_W-1:0]  job_nblk,
   output logic               ks_req,
   output logic [KEY_W-1:0]   ks_req_key,
   input  logic               ks_valid,
   input  logic               ks_last,
   input  logic [DATA_W-1:0]  ks_data,
   output logic               ksw_en,
   output logic [ENG_W-1:0]   ksw_eng,
   output logic [SLOT_W-1:0]  ksw_slot,
   output logic [WORD_W-1:0]  ksw_word,
   output logic [DATA_W-1:0]  ksw_data,
   output logic               iss_valid,
   output logic [ENG_W-1:0]   iss_eng,
   output logic [SLOT_W-1:0]  iss_slot,
   output logic [FLOW_W-1:0]  iss_flow,
   output logic [NBLK_W-1:0]  iss_nblk,
   input  logic [NUM_ENG-1:0] eng_done,
   output logic [NUM_ENG-1:0] eng_busy
);

   if (NUM_ENG < 2) begin : g_chk_eng
      $error("job_row_sched: NUM_ENG must be at least 2");
   end
   if (NUM_SLOT < 2) begin : g_chk_slot
      $error("job_row_sched: NUM_SLOT must be at least 2");
   end
   if (KS_WORDS < 2) begin : g_chk_words
      $error("job_row_sched: KS_WORDS must be at least 2");
   end
   if (NBLK_W < 1 || KEY_W < 1 || FLOW_W < 1) begin : g_chk_w
      $error("job_row_sched: field widths must be positive");
   end

   sched_state_e       state_q;
   logic [ENG_W-1:0]   rr_q;
   logic [ENG_W-1:0]   lat_eng_q;
   logic [SLOT_W-1:0]  lat_slot_q;
   logic [KEY_W-1:0]   lat_key_q;
   logic [FLOW_W-1:0]  lat_flow_q;
   logic [NBLK_W-1:0]  lat_nblk_q;
   logic [WORD_W-1:0]  word_q;

   logic [NUM_ENG-1:0] idle;
   logic [NUM_ENG-1:0] hit_vec;
   logic [NUM_ENG-1:0] hit_idle;
   logic [NUM_ENG-1:0] same_flow;
   logic [FLOW_W-1:0]  eng_flow [NUM_ENG];

   logic               hit_gnt_v, any_gnt_v;
   logic [ENG_W-1:0]   hit_gnt_idx, any_gnt_idx;
   logic [ENG_W-1:0]   pick_eng;
   logic               use_hit;
   logic [SLOT_W-1:0]  sel_hit_slot, sel_victim;

   logic               flow_blocked;
   logic               accept;
   logic               load_end;
   logic               issue_now;
   logic [ENG_W-1:0]   set_eng;
   logic [FLOW_W-1:0]  set_flow;

   assign idle     = ~eng_busy;
   assign hit_idle = hit_vec & idle;

   for (genvar e = 0; e < NUM_ENG; e++) begin : g_flow_cmp
      assign same_flow[e] = eng_busy[e] && (eng_flow[e] == job_flow);
   end
   assign flow_blocked = |same_flow;

   sched_rr_pick #(.N(NUM_ENG)) u_pick_hit (
      .req     (hit_idle),
      .ptr     (rr_q),
      .gnt_v   (hit_gnt_v),
      .gnt_idx (hit_gnt_idx)
   );

   sched_rr_pick #(.N(NUM_ENG)) u_pick_any (
      .req     (idle),
      .ptr     (rr_q),
      .gnt_v   (any_gnt_v),
      .gnt_idx (any_gnt_idx)
   );

   if (PREFER_HIT) begin : g_hit_first
      assign pick_eng = hit_gnt_v ? hit_gnt_idx : any_gnt_idx;
      assign use_hit  = hit_gnt_v;
   end else begin : g_plain_rr
      assign pick_eng = any_gnt_idx;
      assign use_hit  = hit_vec[any_gnt_idx];
   end

   sched_key_tags #(
      .NUM_ENG  (NUM_ENG),
      .NUM_SLOT (NUM_SLOT),
      .KEY_W    (KEY_W)
   ) u_tags (
      .clk          (clk),
      .rst_n        (rst_n),
      .lookup_key   (job_key),
      .sel_eng      (pick_eng),
      .hit_vec      (hit_vec),
      .sel_hit_slot (sel_hit_slot),
      .sel_victim   (sel_victim),
      .wr_en        (load_end),
      .wr_eng       (lat_eng_q),
      .wr_key       (lat_key_q)
   );

   assign job_ready = (state_q == ST_IDLE) && any_gnt_v && !flow_blocked;
   assign accept    = job_valid && job_ready;
   assign load_end  = (state_q == ST_LOAD) && ks_valid && ks_last;
   assign issue_now = (accept && use_hit) || load_end;
   assign set_eng   = load_end ? lat_eng_q  : pick_eng;
   assign set_flow  = load_end ? lat_flow_q : job_flow;

   sched_eng_state #(
      .NUM_ENG (NUM_ENG),
      .FLOW_W  (FLOW_W)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (issue_now),
      .set_eng  (set_eng),
      .set_flow (set_flow),
      .done     (eng_done),
      .busy     (eng_busy),
      .flow     (eng_flow)
   );

   assign ks_req     = (state_q == ST_LOAD);
   assign ks_req_key = lat_key_q;
   assign ksw_en     = (state_q == ST_LOAD) && ks_valid;
   assign ksw_eng    = lat_eng_q;
   assign ksw_slot   = lat_slot_q;
   assign ksw_word   = word_q;
   assign ksw_data   = ks_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         rr_q       <= '0;
         lat_eng_q  <= '0;
         lat_slot_q <= '0;
         lat_key_q  <= '0;
         lat_flow_q <= '0;
         lat_nblk_q <= '0;
         word_q     <= '0;
         iss_valid  <= 1'b0;
         iss_eng    <= '0;
         iss_slot   <= '0;
         iss_flow   <= '0;
         iss_nblk   <= '0;
      end else begin
         iss_valid <= issue_now;
         if (issue_now) begin
            iss_eng  <= set_eng;
            iss_slot <= load_end ? lat_slot_q : sel_hit_slot;
            iss_flow <= set_flow;
            iss_nblk <= load_end ? lat_nblk_q : job_nblk;
         end
         if (accept) begin
            rr_q <= ENG_W'(wrap_inc(int'(pick_eng), NUM_ENG));
         end
         unique case (state_q)
            ST_IDLE: begin
               if (accept && !use_hit) begin
                  state_q    <= ST_LOAD;
                  lat_eng_q  <= pick_eng;
                  lat_slot_q <= sel_victim;
                  lat_key_q  <= job_key;
                  lat_flow_q <= job_flow;
                  lat_nblk_q <= job_nblk;
                  word_q     <= '0;
               end
            end
            ST_LOAD: begin
               if (ks_valid) begin
                  word_q <= word_q + 1'b1;
                  if (ks_last) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/job_row_sched_chk.sv
module job_row_sched_chk #(
   parameter int NUM_ENG = 12,
   parameter int FLOW_W  = 4,
   localparam int ENG_W = $clog2(NUM_ENG)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               job_valid,
   input logic               job_ready,
   input logic               ks_req,
   input logic               ksw_en,
   input logic               iss_valid,
   input logic [ENG_W-1:0]   iss_eng,
   input logic [FLOW_W-1:0]  iss_flow,
   input logic [NUM_ENG-1:0] eng_done,
   input logic [NUM_ENG-1:0] eng_busy,
   input logic [FLOW_W-1:0]  eng_flow [NUM_ENG]
);

   assert_accept_acts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (job_valid && job_ready) |=> (iss_valid || ks_req));

   assert_write_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ksw_en |-> ks_req);

   assert_issue_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> ((($past(eng_busy) >> iss_eng) & NUM_ENG'(1)) == '0));

   assert_issue_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> ((eng_busy >> iss_eng) & NUM_ENG'(1)) != '0);

   assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|eng_done) |=> ((eng_busy & $past(eng_done)) == '0));

   assert_full_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (&eng_busy) |-> !job_ready);

   for (genvar e = 0; e < NUM_ENG; e++) begin : g_flow
      assert_flow_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_valid && eng_busy[e] && iss_eng != ENG_W'(e)) |-> (eng_flow[e] != iss_flow));
   end

endmodule

bind job_row_sched job_row_sched_chk #(
   .NUM_ENG (NUM_ENG),
   .FLOW_W  (FLOW_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .job_valid (job_valid),
   .job_ready (job_ready),
   .ks_req    (ks_req),
   .ksw_en    (ksw_en),
   .iss_valid (iss_valid),
   .iss_eng   (iss_eng),
   .iss_flow  (iss_flow),
   .eng_done  (eng_done),
   .eng_busy  (eng_busy),
   .eng_flow  (eng_flow)
);

// File: tb/job_row_sched_tb.sv
`timescale 1ns/1ps
module job_row_sched_tb;

   localparam int NE = 12;
   localparam int NW = 11;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         job_valid = 1'b0;
   logic         job_ready;
   logic [3:0]   job_flow = '0;
   logic [7:0]   job_key = '0;
   logic [4:0]   job_nblk = '0;
   logic         ks_req;
   logic [7:0]   ks_req_key;
   logic         ks_valid = 1'b0;
   logic         ks_last = 1'b0;
   logic [127:0] ks_data = '0;
   logic         ksw_en;
   logic [3:0]   ksw_eng;
   logic [2:0]   ksw_slot;
   logic [3:0]   ksw_word;
   logic [127:0] ksw_data;
   logic         iss_valid;
   logic [3:0]   iss_eng;
   logic [2:0]   iss_slot;
   logic [3:0]   iss_flow;
   logic [4:0]   iss_nblk;
   logic [NE-1:0] eng_done = '0;
   logic [NE-1:0] eng_busy;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   job_row_sched u_dut (
      .clk(clk), .rst_n(rst_n),
      .job_valid(job_valid), .job_ready(job_ready),
      .job_flow(job_flow), .job_key(job_key), .job_nblk(job_nblk),
      .ks_req(ks_req), .ks_req_key(ks_req_key),
      .ks_valid(ks_valid), .ks_last(ks_last), .ks_data(ks_data),
      .ksw_en(ksw_en), .ksw_eng(ksw_eng), .ksw_slot(ksw_slot),
      .ksw_word(ksw_word), .ksw_data(ksw_data),
      .iss_valid(iss_valid), .iss_eng(iss_eng), .iss_slot(iss_slot),
      .iss_flow(iss_flow), .iss_nblk(iss_nblk),
      .eng_done(eng_done), .eng_busy(eng_busy)
   );

   // {flow[3:0], key[7:0], expected engine[3:0], expected slot[2:0], miss}
   localparam logic [19:0] VEC [0:6] = '{
      {4'd1, 8'h10, 4'd0, 3'd0, 1'b1},
      {4'd2, 8'h10, 4'd0, 3'd0, 1'b0},
      {4'd3, 8'h20, 4'd1, 3'd0, 1'b1},
      {4'd3, 8'h10, 4'd0, 3'd0, 1'b0},
      {4'd4, 8'h30, 4'd1, 3'd1, 1'b1},
      {4'd5, 8'h20, 4'd1, 3'd0, 1'b0},
      {4'd6, 8'h40, 4'd2, 3'd0, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      job_valid = 1'b0;
      ks_valid = 1'b0;
      ks_last = 1'b0;
      eng_done = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(job_ready == 1'b1, "R1", "job_ready after reset", longint'(job_ready), 1);
      chk(eng_busy == '0, "R1", "eng_busy after reset", longint'(eng_busy), 0);
      chk(iss_valid == 1'b0 && ks_req == 1'b0, "R1", "iss_valid/ks_req after reset",
          longint'({iss_valid, ks_req}), 0);
   endtask

   task automatic pulse_done(input int e);
      @(negedge clk);
      eng_done[e] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      eng_done = '0;
      chk(eng_busy[e] == 1'b0, "R9", "busy after done", longint'(eng_busy[e]), 0);
   endtask

   task automatic send_job(input int flow, input int key, input int nblk,
                           input int exp_eng, input int exp_slot, input bit exp_miss,
                           input logic [NE-1:0] done_mask);
      int guard = 0;
      @(negedge clk);
      job_valid = 1'b1;
      job_flow  = 4'(flow);
      job_key   = 8'(key);
      job_nblk  = 5'(nblk);
      eng_done  = done_mask;
      #1;
      while (!job_ready && guard < 1000) begin
         @(negedge clk);
         #1;
         guard++;
      end
      @(posedge clk);
      @(negedge clk);
      job_valid = 1'b0;
      if (done_mask != '0) begin
         chk((eng_busy & done_mask) == '0, "R9", "done cleared in accept cycle",
             longint'(eng_busy & done_mask), 0);
      end
      eng_done = '0;
      if (exp_miss) begin
         chk(ks_req == 1'b1 && ks_req_key == 8'(key), "R3", "schedule request key",
             longint'({ks_req, ks_req_key}), longint'({1'b1, 8'(key)}));
         chk(iss_valid == 1'b0, "R3", "no issue before load", longint'(iss_valid), 0);
         for (int w = 0; w < NW; w++) begin
            ks_valid = 1'b1;
            ks_last  = (w == NW - 1);
            ks_data  = {32'hC0DE0000 + 32'(key), 32'(exp_eng), 32'(w), 32'hA5A5A5A5};
            #1;
            chk(ksw_en && ksw_eng == 4'(exp_eng) && ksw_slot == 3'(exp_slot) &&
                ksw_word == 4'(w), "R4", "write port eng/slot/word",
                longint'({ksw_en, ksw_eng, ksw_slot, ksw_word}),
                longint'({1'b1, 4'(exp_eng), 3'(exp_slot), 4'(w)}));
            chk(ksw_data == ks_data, "R4", "write data", longint'(ksw_data[63:0]),
                longint'(ks_data[63:0]));
            @(posedge clk);
            @(negedge clk);
         end
         ks_valid = 1'b0;
         ks_last  = 1'b0;
         chk(iss_valid == 1'b1 && ks_req == 1'b0, "R5", "issue after last beat",
             longint'({iss_valid, ks_req}), 2);
      end else begin
         chk(ks_req == 1'b0, "R2", "hit needs no schedule", longint'(ks_req), 0);
         chk(iss_valid == 1'b1, "R2", "issue one cycle after accept", longint'(iss_valid), 1);
      end
      chk(iss_eng == 4'(exp_eng), exp_miss ? "R7" : "R2", "issued engine",
          longint'(iss_eng), longint'(exp_eng));
      chk(iss_slot == 3'(exp_slot), exp_miss ? "R6" : "R2", "issued slot",
          longint'(iss_slot), longint'(exp_slot));
      chk(iss_flow == 4'(flow) && iss_nblk == 5'(nblk), "R12", "issued flow/count",
          longint'({iss_flow, iss_nblk}), longint'({4'(flow), 5'(nblk)}));
      chk(eng_busy[exp_eng] == 1'b1, "R8", "engine busy after issue",
          longint'(eng_busy[exp_eng]), 1);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++;
         $display("FAIL R1 watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();

      // R2 R3 R6 R7: vector table, each job completes before the next
      for (int i = 0; i < 7; i++) begin
         send_job(int'(VEC[i][19:16]), int'(VEC[i][15:8]), i + 1,
                  int'(VEC[i][7:4]), int'(VEC[i][3:1]), VEC[i][0], '0);
         pulse_done(int'(VEC[i][7:4]));
      end

      // R10: flow 7 runs on engine 0, a second flow-7 job must wait
      send_job(7, 8'h10, 16, 0, 0, 1'b0, '0);
      @(negedge clk);
      job_valid = 1'b1;
      job_flow  = 4'd7;
      job_key   = 8'h50;
      job_nblk  = 5'd1;
      for (int c = 0; c < 3; c++) begin
         #1;
         chk(job_ready == 1'b0, "R10", "same-flow job held", longint'(job_ready), 0);
         @(negedge clk);
      end
      job_valid = 1'b0;
      pulse_done(0);
      send_job(7, 8'h50, 1, 1, 2, 1'b1, '0);     // R6: engine 1 third victim slot

      // R8: key 0x30 only on busy engine 1, so miss to engine 2 slot 1
      send_job(8, 8'h30, 3, 2, 1, 1'b1, '0);

      // R9: engine 1 done in the accept cycle; key 0x20 only there, still a miss
      send_job(9, 8'h20, 2, 3, 0, 1'b1, 12'h002);
      // R2: now engine 1 idle and holds 0x20
      send_job(10, 8'h20, 4, 1, 0, 1'b0, '0);

      // R11: fill every engine after a fresh reset
      do_reset();
      for (int e = 0; e < NE; e++) begin
         send_job(e, 8'h77, 1, e, 0, 1'b1, '0);
      end
      @(negedge clk);
      job_valid = 1'b1;
      job_flow  = 4'd12;
      job_key   = 8'h77;
      job_nblk  = 5'd16;
      #1;
      chk(job_ready == 1'b0, "R11", "ready with all engines busy", longint'(job_ready), 0);
      chk(eng_busy == 12'hFFF, "R8", "all engines busy", longint'(eng_busy), 12'hFFF);
      job_valid = 1'b0;
      pulse_done(5);
      send_job(12, 8'h77, 16, 5, 0, 1'b0, '0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule